// File: doc/BRIEF.md
# Backplane Slot Position Reset Configuration

This block sets the reset state of a backplane board's configuration-space window. While the active-low power-up reset is held, it samples a group of strap bits from the data lines and the five geographic address pins on every clock. The values present at the last clock before power-up reset releases become a fixed snapshot.

The window enable bit and the base-address field come from that snapshot. When the geographic-enable strap is set, the window comes out of reset enabled, and its base address is the bitwise inverse of the geographic pins. A later active-low system reset reloads the window from the snapshot, not from constants.

The block also holds a system-fail flag, which drives the system-fail output directly. In automatic slot-numbering mode, system reset sets the flag. Depending on a strap, the flag is then cleared by hardware one clock after system reset releases, or it waits for software to clear it. A two-entry register port lets software read and change the window fields and the flag.

Top module: `slotIdCfg`

## Requirements
- R1: The straps and geographic pins are captured on every clock while `purstN` is 0. Once `purstN` is 1, later changes on `strapData` and `geoAddr` have no effect on any register or output. Strap positions in `strapData` are: bit 0 automatic-slot-number enable, bit 1 auto-clear select, bit 2 initial fail flag, bit 3 geographic enable.
- R2: If the geographic-enable strap is 0 at capture, the window enable and the base field are both 0.
- R3: If the geographic-enable strap is 1 at capture, the window enable is 1 and the base field is `~geoAddr`. Register 0 reads as {base[4:0], 2'b00, enable}.
- R4: While `sysRstN` is 0 and `purstN` is 1, each clock reloads the window enable and base field from the snapshot.
- R5: While `sysRstN` is 0, the fail flag is set if the automatic-slot-number strap is 1, and left unchanged if that strap is 0.
- R6: `sysFailOut` is 1 exactly when the fail flag is 1.
- R7: With the auto-clear strap at 0, the flag stays set after system reset until software writes register 1 with bit 0 equal to 0.
- R8: After power-up the flag equals the initial-fail strap. A software write to register 1 bit 0 sets or clears the flag.
- R9: A write to register 0 takes effect at the next clock edge. Bits 2:1 are not stored and read as 0.
- R10: Register writes presented while `sysRstN` is 0 are ignored.
- R11: With both the automatic-slot-number and auto-clear straps at 1, the flag clears at the first clock edge that samples `sysRstN` high after a system reset. Until then the output stays asserted.
- R12: A write to register 1 in that release cycle takes priority over the hardware auto-clear.
- R13: Register 1 reads {4'b0, geographic enable, auto-clear, automatic-slot enable, flag}. Its strap bits are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| purstN | input | 1 | Power-up reset, active low; straps are captured while it is low |
| sysRstN | input | 1 | System reset, active low |
| strapData | input | 8 | Strap bits sampled from the data lines |
| geoAddr | input | 5 | Geographic address pins, already synchronised |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 window, 1 control |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register (combinational) |
| sysFailOut | output | 1 | System-fail output, active high |

## Verification
Two pairs of functions can act in the same clock. The first pair is a software write and a system-reset reload. The bench provokes it by writing register 0 while `sysRstN` is low, and then reads back the snapshot-derived window, not the written value. The second pair is a software write to the fail flag and the hardware auto-clear. The bench writes 1 to the flag in the same cycle that `sysRstN` rises, then checks that the flag and `sysFailOut` are still 1 after that edge. The same release edge without a write is checked separately, and there the output must drop.

// File: rtl/slot_cfg_pkg.sv
package slot_cfg_pkg;
  typedef struct packed {
    logic capture;   // power-up reset held: take straps
    logic reload;    // system reset held: reload window from snapshot
    logic setFail;   // system reset in automatic mode
    logic clrFail;   // hardware auto-clear on system reset release
    logic wrWin;     // software write to window register
    logic wrFail;    // software write to control register
  } ctlStrobes_t;
endpackage

// File: rtl/slotCfgCtrl.sv
module slotCfgCtrl
  import slot_cfg_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              purstN,
  input  logic              sysRstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              autoSlot,
  input  logic              autoClr,
  output ctlStrobes_t       strb
);
  localparam logic [ADDR_W-1:0] WIN_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(1);

  logic sysRstQ;
  logic running;
  logic released;
  logic swOk;

  always_ff @(posedge clk) begin
    sysRstQ <= purstN ? sysRstN : 1'b1;
  end

  assign running  = purstN;
  assign released = running && sysRstN && !sysRstQ;
  assign swOk     = running && sysRstN && regWrEn;

  always_comb begin
    strb         = '0;
    strb.capture = !purstN;
    strb.reload  = running && !sysRstN;
    strb.setFail = strb.reload && autoSlot;
    strb.wrWin   = swOk && (regAddr == WIN_ADDR);
    strb.wrFail  = swOk && (regAddr == CTL_ADDR);
    strb.clrFail = released && autoSlot && autoClr && !strb.wrFail;
  end

  AST_ONE_SOURCE_FLAG: assert property (@(posedge clk) disable iff (!purstN)
    !(strb.setFail && strb.wrFail)) else $error("flag set and write together"); // R10

  AST_RELEASE_ONLY_AFTER_RESET: assert property (@(posedge clk) disable iff (!purstN)
    strb.clrFail |-> $past(!sysRstN)) else $error("auto-clear without reset"); // R11
endmodule

// File: rtl/slotCfgPath.sv
module slotCfgPath
  import slot_cfg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int GA_W     = 5,
  parameter int ADDR_W   = 1,
  parameter int ASLOT_BIT = 0,
  parameter int ACLR_BIT  = 1,
  parameter int FINIT_BIT = 2,
  parameter int GEO_BIT   = 3
) (
  input  logic              clk,
  input  logic              purstN,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] strapData,
  input  logic [GA_W-1:0]   geoAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              autoSlotQ,
  output logic              autoClrQ,
  output logic              failFlag
);
  localparam int PAD_W  = DATA_W - GA_W - 1;
  localparam int CPAD_W = DATA_W - 4;
  localparam int BASE_LO = DATA_W - GA_W;

  logic            geoEnQ;
  logic [GA_W-1:0] geoQ;
  logic            winEn;
  logic [GA_W-1:0] winBase;
  logic [GA_W-1:0] liveInv;
  logic [GA_W-1:0] snapInv;
  logic [GA_W-1:0] liveBase;
  logic [GA_W-1:0] snapBase;

  for (genvar i = 0; i < GA_W; i++) begin : g_inv
    assign liveInv[i] = ~geoAddr[i];
    assign snapInv[i] = ~geoQ[i];
  end

  assign liveBase = strapData[GEO_BIT] ? liveInv : '0;
  assign snapBase = geoEnQ ? snapInv : '0;

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      geoEnQ    <= strapData[GEO_BIT];
      autoSlotQ <= strapData[ASLOT_BIT];
      autoClrQ  <= strapData[ACLR_BIT];
      geoQ      <= geoAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      winEn   <= strapData[GEO_BIT];
      winBase <= liveBase;
    end else if (strb.reload) begin
      winEn   <= geoEnQ;
      winBase <= snapBase;
    end else if (strb.wrWin) begin
      winEn   <= regWrData[0];
      winBase <= regWrData[DATA_W-1:BASE_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.capture)      failFlag <= strapData[FINIT_BIT];
    else if (strb.setFail) failFlag <= 1'b1;
    else if (strb.wrFail)  failFlag <= regWrData[0];
    else if (strb.clrFail) failFlag <= 1'b0;
  end

  always_comb begin
    if (regAddr == ADDR_W'(0))
      regRdData = {winBase, {PAD_W{1'b0}}, winEn};
    else
      regRdData = {{CPAD_W{1'b0}}, geoEnQ, autoClrQ, autoSlotQ, failFlag};
  end

  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!purstN)
    $past(purstN) |-> $stable({geoEnQ, autoSlotQ, autoClrQ, geoQ})) else $error("snapshot moved"); // R1

  AST_RELOAD_WINDOW: assert property (@(posedge clk) disable iff (!purstN)
    strb.reload |=> (winEn == $past(geoEnQ)) && (winBase == $past(snapBase))) else $error("reload"); // R4

  AST_FAIL_SET: assert property (@(posedge clk) disable iff (!purstN)
    strb.setFail |=> failFlag) else $error("fail not set"); // R5

  AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!purstN)
    $fell(failFlag) |-> $past(strb.clrFail || strb.wrFail)) else $error("flag fell"); // R7

  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!purstN)
    strb.clrFail |=> !failFlag) else $error("auto-clear missed"); // R11
endmodule

// File: rtl/slotIdCfg.sv
module slotIdCfg
  import slot_cfg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GA_W   = 5,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              purstN,
  input  logic              sysRstN,
  input  logic [DATA_W-1:0] strapData,
  input  logic [GA_W-1:0]   geoAddr,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sysFailOut
);
  ctlStrobes_t strb;
  logic autoSlot;
  logic autoClr;
  logic failFlag;

  slotCfgCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .purstN(purstN), .sysRstN(sysRstN), .regWrEn(regWrEn),
    .regAddr(regAddr), .autoSlot(autoSlot), .autoClr(autoClr), .strb(strb)
  );

  slotCfgPath #(.DATA_W(DATA_W), .GA_W(GA_W), .ADDR_W(ADDR_W)) u_path (
    .clk(clk), .purstN(purstN), .strb(strb), .strapData(strapData),
    .geoAddr(geoAddr), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .autoSlotQ(autoSlot), .autoClrQ(autoClr),
    .failFlag(failFlag)
  );

  assign sysFailOut = failFlag;

  AST_FAIL_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!purstN)
    (!sysRstN && autoSlot) |=> sysFailOut) else $error("fail output dropped"); // R6
endmodule

// File: tb/sim_slotIdCfg.sv
module sim_slotIdCfg;
  logic       clk = 1'b0;
  logic       purstN = 1'b0;
  logic       sysRstN = 1'b1;
  logic [7:0] strapData = '0;
  logic [4:0] geoAddr = '0;
  logic       regWrEn = 1'b0;
  logic [0:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       sysFailOut;

  typedef struct {
    bit       isFail;
    bit [7:0] exp;
    string    tag;
  } item_t;
  item_t sb[$];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slotIdCfg u0 (
    .clk(clk), .purstN(purstN), .sysRstN(sysRstN), .strapData(strapData),
    .geoAddr(geoAddr), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sysFailOut(sysFailOut)
  );

  // Monitor: compares everything queued since the last falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      bit [7:0] act;
      it = sb.pop_front();
      act = it.isFail ? {7'b0, sysFailOut} : regRdData;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expRd(input bit a, input bit [7:0] e, input string tag);
    regAddr = a;
    sb.push_back('{1'b0, e, tag});
  endtask

  task automatic expFail(input bit e, input string tag);
    sb.push_back('{1'b1, {7'b0, e}, tag});
  endtask

  task automatic wr(input bit a, input bit [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step(1);
    regWrEn = 1'b0;
  endtask

  task automatic powerUp(input bit [7:0] s, input bit [4:0] g);
    purstN = 1'b0; sysRstN = 1'b1;
    strapData = s; geoAddr = g;
    step(3);
    purstN = 1'b1;
    step(1);
  endtask

  task automatic settle();
    @(negedge clk); #1;
    step(1);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 5000 && !done; wd++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(1);
    // Power-up: geo=1, init fail=1, auto-clear=0, auto slot=1; geo pins 10110 -> base 01001
    powerUp(8'h0D, 5'b10110);
    expRd(0, 8'h49, "R3 window from inverted pins");
    settle();
    expRd(1, 8'h0B, "R13 control layout");
    expFail(1'b1, "R8 initial flag from strap");
    settle();
    strapData = 8'h00; geoAddr = 5'b00000;
    step(2);
    expRd(0, 8'h49, "R1 straps ignored after power-up");
    settle();
    expRd(1, 8'h0B, "R1 control straps frozen");
    settle();
    // Software clears flag (manual mode)
    wr(1, 8'h00);
    expRd(1, 8'h0A, "R7 software clear");
    expFail(1'b0, "R6 output follows flag");
    settle();
    wr(0, 8'hF8);
    expRd(0, 8'hF8, "R9 window write next clock");
    settle();
    wr(0, 8'hFF);
    expRd(0, 8'hF9, "R9 unused bits read zero");
    settle();
    wr(1, 8'h0E);
    expRd(1, 8'h0A, "R13 strap bits read-only");
    settle();
    // System reset with concurrent write
    sysRstN = 1'b0; regWrEn = 1'b1; regAddr = 0; regWrData = 8'h00;
    step(1);
    regWrEn = 1'b0;
    expRd(0, 8'h49, "R10 write ignored, R4 reload");
    expFail(1'b1, "R5 flag set by system reset");
    settle();
    sysRstN = 1'b0;
    step(1);
    sysRstN = 1'b1;
    step(3);
    expFail(1'b1, "R7 manual mode holds flag");
    settle();
    wr(1, 8'h00);
    expFail(1'b0, "R7 cleared by software");
    settle();

    // Power-up: geo=0, init fail=0, auto-clear=1, auto slot=1
    powerUp(8'h03, 5'b01010);
    expRd(0, 8'h00, "R2 geographic disabled");
    settle();
    expRd(1, 8'h06, "R13 control after second power-up");
    expFail(1'b0, "R8 initial flag clear");
    settle();
    wr(0, 8'hA9);
    expRd(0, 8'hA9, "R9 write");
    settle();
    sysRstN = 1'b0;
    step(2);
    expRd(0, 8'h00, "R4 reload to cleared window");
    expFail(1'b1, "R5 flag set");
    settle();
    sysRstN = 1'b1;
    expFail(1'b1, "R11 asserted before release edge");
    @(negedge clk); #1;
    step(1);
    expFail(1'b0, "R11 auto-clear after release");
    settle();
    expRd(1, 8'h06, "R11 flag bit clear");
    settle();
    // Release cycle with concurrent flag write
    sysRstN = 1'b0;
    step(2);
    sysRstN = 1'b1; regWrEn = 1'b1; regAddr = 1; regWrData = 8'h01;
    step(1);
    regWrEn = 1'b0;
    expFail(1'b1, "R12 write beats auto-clear");
    settle();
    step(2);
    expFail(1'b1, "R12 flag stays");
    settle();
    wr(1, 8'h00);

    // Power-up: geo=1, init fail=0, auto-clear=1, auto slot=0; pins 00000 -> base 11111
    powerUp(8'h0A, 5'b00000);
    expRd(0, 8'hF9, "R3 all-ones base");
    settle();
    sysRstN = 1'b0;
    step(2);
    expFail(1'b0, "R5 no set without automatic mode");
    settle();
    sysRstN = 1'b1;
    step(1);
    wr(1, 8'h01);
    expFail(1'b1, "R8 software sets flag");
    settle();
    sysRstN = 1'b0;
    step(2);
    sysRstN = 1'b1;
    step(2);
    expFail(1'b1, "R11 no auto-clear without automatic mode");
    settle();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule